// File: doc/BRIEF.md
# Horizontal Drive Pulse Shaper with X-Ray Safety Latch

This block produces the horizontal output-stage drive for a deflection controller. A digital timing front end delivers a strobe at the start of every horizontal period together with the measured length of that period in clock cycles. At each strobe the block works out how many cycles the output transistor must stay off. It holds the drive low for that many cycles and then drives it high until the next strobe. A 5-bit duty code selects the off-time. The code is inverted, so a larger code gives a shorter off-time. The range runs from 60% of the period at code 0 down to 30% at code 31.

Around that pulse generator sit the safety gates. A low supply, the flyback interval, a cleared enable bit or a latched X-ray fault each force the drive off within one clock. Once the drive has been stopped, it comes back only at the next period start, so the power stage never sees a shortened conduction pulse. The X-ray comparator input is brought through a synchroniser into a sticky latch. While the latch is set, both the drive and the switching-regulator enable are removed. The latch state is also brought out as a status bit, and only a reset or a software clear bit releases it.

Top module: `hdrv_shaper`

## Requirements
- R1: After a period-start strobe with period P and duty code c, `hdrive` (1 = transistor conducting, 0 = off) is 0 for exactly N cycles and then 1 until the next strobe, unless an inhibit occurs. N = floor((P*(1860-30*c)+1550)/3100), which is P*(60% - c*30%/31) rounded half up. The cycle count starts with the cycle that follows the strobe edge. Code 31 gives 30% and code 0 gives 60%.
- R2: The first period after reset uses code 0 (60% off-time), whatever value is on `duty_code`.
- R3: From reset until the first strobe, `hdrive` is 0, `reg_en` is 1 and `xray_status` is 0.
- R4: When `supply_low` = 1, `flyback` = 1 or `drive_en` = 0 is seen at a clock edge, `hdrive` is 0 after that edge.
- R5: When `xray_in` is high at edge t, `xray_status` becomes 1 after edge t+2 (two synchroniser flops). While `xray_status` is 1, both `hdrive` and `reg_en` are 0.
- R6: Once set, the latch stays set through period strobes. Only reset or `xray_clr` = 1 at an edge clears it. When the synchronised X-ray input and `xray_clr` are both active, the set wins.
- R7: After an inhibit ends partway through a period, `hdrive` stays 0 until a strobe arrives at which no inhibit is present. No truncated pulse is produced.
- R8: The off-time is computed only at the strobe, from the `period_cnt` and `duty_code` present at that edge. A change of `duty_code` during the period does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on / supply power-down) |
| period_start | input | 1 | One-cycle strobe marking the start of a horizontal period |
| period_cnt | input | 12 | Measured horizontal period in clock cycles |
| flyback | input | 1 | Flyback interval in progress |
| supply_low | input | 1 | Supply monitor reports undervoltage |
| xray_in | input | 1 | X-ray comparator output (asynchronous) |
| drive_en | input | 1 | Control bit: 1 allows drive |
| xray_clr | input | 1 | Control bit: clears the X-ray latch |
| duty_code | input | 5 | Inverted off-time code (0 = 60%, 31 = 30%) |
| hdrive | output | 1 | Horizontal drive (1 = conduct) |
| reg_en | output | 1 | Switching-regulator enable |
| xray_status | output | 1 | X-ray latch state |

## Verification
The hardest state to reach is a collision between a pending X-ray set and a software clear. The set has to win even though the clear bit is already high while the fault is still passing through the synchroniser. The bench holds the X-ray input high long enough to fill the synchroniser and then raises the clear. It keeps the clear asserted until the synchroniser drains, and confirms that the latch releases only after that. A second hard case is an inhibit that ends in the middle of the on-phase. The bench pulses the supply flag for one cycle inside the conduction window and watches that the drive stays low up to the following strobe. Randomised periods, codes and sparse inhibits are then checked every cycle against a bench reference model.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

   // scale used for percentage arithmetic
   localparam int PCT_SCALE = 100;

   // reasons that force the drive off
   typedef struct packed {
      logic supply;
      logic flyback;
      logic disabled;
      logic xray;
   } hdrv_inhibit_t;

   function automatic logic any_inhibit(input hdrv_inhibit_t r);
      return r.supply | r.flyback | r.disabled | r.xray;
   endfunction

endpackage

// File: rtl/hdrv_offcalc.sv
module hdrv_offcalc #(
   parameter int PW      = 12,
   parameter int CW      = 5,
   parameter int MAX_PCT = 60,
   parameter int MIN_PCT = 30
) (
   input  logic [PW-1:0] period,
   input  logic [CW-1:0] code,
   output logic [PW-1:0] off_cycles
);
   import hdrv_pkg::*;

   localparam int CODE_MAX = (1 << CW) - 1;
   localparam int DEN      = PCT_SCALE * CODE_MAX;
   localparam int TOPF     = MAX_PCT * CODE_MAX;
   localparam int STEP     = MAX_PCT - MIN_PCT;
   localparam int FW       = $clog2(DEN + 1) + 1;
   localparam int NW       = PW + FW;

   generate
      if (MIN_PCT >= MAX_PCT || MAX_PCT > PCT_SCALE || MIN_PCT < 0) begin : g_bad_pct
         $error("hdrv_offcalc: percent range must satisfy 0 <= MIN < MAX <= 100");
      end
      if (CW < 1) begin : g_bad_cw
         $error("hdrv_offcalc: code width must be at least 1");
      end
   endgenerate

   logic [FW-1:0] factor;
   logic [NW-1:0] product;
   logic [NW-1:0] quotient;

   always_comb begin
      factor     = FW'(TOPF) - FW'(STEP) * FW'(code);
      product    = NW'(period) * NW'(factor) + NW'(DEN / 2);
      quotient   = product / NW'(DEN);
      off_cycles = PW'(quotient);
   end

endmodule

// File: rtl/hdrv_xray_guard.sv
module hdrv_xray_guard #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xray_in,
   input  logic xray_clr,
   output logic latched
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hdrv_xray_guard: at least two synchroniser stages required");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   latch_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= xray_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      latch_q <= 1'b0;
      else if (sync_q[SYNC_STAGES-1]) latch_q <= 1'b1;
      else if (xray_clr)              latch_q <= 1'b0;
   end

   assign latched = latch_q;

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_q && !xray_clr |=> latch_q);

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q[SYNC_STAGES-1] |=> latch_q);

   // R6
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_q && !sync_q[SYNC_STAGES-1] |=> !latch_q);

endmodule

// File: rtl/hdrv_phase.sv
module hdrv_phase #(
   parameter int PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          period_start,
   input  logic          inhibit,
   input  logic [PW-1:0] off_new,
   output logic          on_phase
);

   localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

   logic [PW-1:0] pos_q;
   logic [PW-1:0] off_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         off_q   <= '0;
         armed_q <= 1'b0;
      end else if (period_start) begin
         pos_q   <= '0;
         off_q   <= off_new;
         armed_q <= !inhibit;
      end else begin
         if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
         if (inhibit)          armed_q <= 1'b0;
      end
   end

   assign on_phase = armed_q && (pos_q >= off_q);

   // R7
   arm_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(period_start));

   // R8
   off_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |=> $stable(off_q));

endmodule

// File: rtl/hdrv_shaper.sv
module hdrv_shaper #(
   parameter int PW          = 12,
   parameter int CW          = 5,
   parameter int MAX_PCT     = 60,
   parameter int MIN_PCT     = 30,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          period_start,
   input  logic [PW-1:0] period_cnt,
   input  logic          flyback,
   input  logic          supply_low,
   input  logic          xray_in,
   input  logic          drive_en,
   input  logic          xray_clr,
   input  logic [CW-1:0] duty_code,
   output logic          hdrive,
   output logic          reg_en,
   output logic          xray_status
);
   import hdrv_pkg::*;

   logic          xlatch;
   logic          first_q;
   logic [CW-1:0] code_eff;
   logic [PW-1:0] off_new;
   logic          on_phase;
   hdrv_inhibit_t why;
   logic          inhibit;

   // first period after reset always uses the longest off-time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            first_q <= 1'b1;
      else if (period_start) first_q <= 1'b0;
   end

   assign code_eff = first_q ? '0 : duty_code;

   always_comb begin
      why.supply   = supply_low;
      why.flyback  = flyback;
      why.disabled = !drive_en;
      why.xray     = xlatch;
      inhibit      = any_inhibit(why);
   end

   hdrv_xray_guard #(.SYNC_STAGES(SYNC_STAGES)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .xray_in  (xray_in),
      .xray_clr (xray_clr),
      .latched  (xlatch)
   );

   hdrv_offcalc #(.PW(PW), .CW(CW), .MAX_PCT(MAX_PCT), .MIN_PCT(MIN_PCT)) u_calc (
      .period     (period_cnt),
      .code       (code_eff),
      .off_cycles (off_new)
   );

   hdrv_phase #(.PW(PW)) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_start (period_start),
      .inhibit      (inhibit),
      .off_new      (off_new),
      .on_phase     (on_phase)
   );

   assign hdrive      = on_phase && !xlatch;
   assign reg_en      = !xlatch;
   assign xray_status = xlatch;

   // R1
   off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start && (off_new != '0) |=> !hdrive);

   // R4
   inhibit_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_low || flyback || !drive_en) |=> !hdrive);

   // R5
   xray_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xray_status |-> (!hdrive && !reg_en));

   // R3
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (!hdrive && reg_en && !xray_status));

endmodule

// File: tb/hdrv_shaper_tb.sv
module hdrv_shaper_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        period_start = 1'b0;
   logic [11:0] period_cnt = '0;
   logic        flyback = 1'b0;
   logic        supply_low = 1'b0;
   logic        xray_in = 1'b0;
   logic        drive_en = 1'b1;
   logic        xray_clr = 1'b0;
   logic [4:0]  duty_code = '0;
   logic        hdrive, reg_en, xray_status;

   int checks = 0;
   int fails = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   string cur_req = "R3";

   always #(CLK_PERIOD/2) clk = ~clk;

   hdrv_shaper u_dut (
      .clk(clk), .rst_n(rst_n), .period_start(period_start), .period_cnt(period_cnt),
      .flyback(flyback), .supply_low(supply_low), .xray_in(xray_in), .drive_en(drive_en),
      .xray_clr(xray_clr), .duty_code(duty_code), .hdrive(hdrive), .reg_en(reg_en),
      .xray_status(xray_status)
   );

   function automatic int off_exp(input int p, input int c);
      return (p * (1860 - 30 * c) + 1550) / 3100;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model, built from the requirements
   int m_pos, m_off;
   bit m_armed, m_first, m_x1, m_x2, m_lat;

   always @(posedge clk) begin
      bit inh;
      if (!rst_n) begin
         m_pos = 0; m_off = 0; m_armed = 0; m_first = 1;
         m_x1 = 0; m_x2 = 0; m_lat = 0;
      end else begin
         inh = supply_low | flyback | !drive_en | m_lat;
         if (period_start) begin
            m_pos = 0;
            m_off = off_exp(int'(period_cnt), m_first ? 0 : int'(duty_code));
            m_first = 0;
            m_armed = !inh;
         end else begin
            if (m_pos < 4095) m_pos++;
            if (inh) m_armed = 0;
         end
         if (m_x2) m_lat = 1;
         else if (xray_clr) m_lat = 0;
         m_x2 = m_x1;
         m_x1 = xray_in;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk({cur_req, " hdrive"}, int'(hdrive), int'(m_armed && !m_lat && m_pos >= m_off));
         chk({cur_req, " reg_en"}, int'(reg_en), int'(!m_lat));
         chk({cur_req, " xray_status"}, int'(xray_status), int'(m_lat));
      end
   end

   task automatic report();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      fails++; checks++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      report();
   end

   task automatic strobe(input int p, input int c);
      @(negedge clk);
      period_start = 1'b1; period_cnt = 12'(p); duty_code = 5'(c); flyback = 1'b0;
      @(negedge clk);
      period_start = 1'b0;
   endtask

   task automatic measure_low(inout int n);
      while (hdrive == 1'b0 && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      void'($urandom(32'd4711));
      // R3: reset state
      repeat (5) @(negedge clk);
      chk("R3 hdrive", int'(hdrive), 0);
      chk("R3 reg_en", int'(reg_en), 1);
      chk("R3 xray_status", int'(xray_status), 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3 hdrive before strobe", int'(hdrive), 0);

      // R2: first period ignores code
      cur_req = "R2";
      strobe(100, 31);
      n = 0; measure_low(n);
      chk("R2 first-period off cycles", n, 60);

      // R1: both ends of the code range
      cur_req = "R1";
      strobe(100, 31);
      n = 0; measure_low(n);
      chk("R1 code 31 off cycles", n, off_exp(100, 31));
      strobe(200, 0);
      n = 0; measure_low(n);
      chk("R1 code 0 off cycles", n, 120);
      strobe(157, 13);
      n = 0; measure_low(n);
      chk("R1 code 13 off cycles", n, off_exp(157, 13));

      // R8: code change mid-period has no effect
      cur_req = "R8";
      strobe(100, 0);
      repeat (9) @(negedge clk);
      duty_code = 5'd31;
      n = 9; measure_low(n);
      chk("R8 off cycles after mid-period code change", n, 60);

      // R4 / R7: single-cycle supply dip inside the on-phase
      cur_req = "R4";
      strobe(100, 31);
      repeat (40) @(negedge clk);
      chk("R1 conducting before dip", int'(hdrive), 1);
      supply_low = 1'b1;
      @(negedge clk);
      supply_low = 1'b0;
      chk("R4 drive off after supply dip", int'(hdrive), 0);
      cur_req = "R7";
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R7 no restart mid-period", int'(hdrive), 0);
      end
      drive_en = 1'b0;
      @(negedge clk);
      drive_en = 1'b1;
      chk("R4 drive_en cleared", int'(hdrive), 0);
      strobe(100, 31);
      n = 0; measure_low(n);
      chk("R7 resumes after strobe", n, off_exp(100, 31));

      // R5: X-ray latency and gating
      cur_req = "R5";
      @(negedge clk);
      xray_in = 1'b1;
      @(negedge clk);
      xray_in = 1'b0;
      @(negedge clk);
      chk("R5 status still clear after two edges", int'(xray_status), 0);
      @(negedge clk);
      chk("R5 status set after third edge", int'(xray_status), 1);
      chk("R5 drive off", int'(hdrive), 0);
      chk("R5 regulator off", int'(reg_en), 0);

      // R6: persistence, clear, set wins
      cur_req = "R6";
      strobe(80, 20);
      repeat (70) @(negedge clk);
      chk("R6 latch survives strobe", int'(xray_status), 1);
      chk("R6 drive stays off", int'(hdrive), 0);
      xray_clr = 1'b1;
      @(negedge clk);
      xray_clr = 1'b0;
      chk("R6 cleared by control bit", int'(xray_status), 0);
      xray_in = 1'b1;
      repeat (3) @(negedge clk);
      xray_clr = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 set wins over clear", int'(xray_status), 1);
      xray_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 clear holds off while sync drains", int'(xray_status), 0);
      xray_clr = 1'b0;

      // randomised periods with sparse inhibits (R1 R4 R5 R6 R7)
      cur_req = "R1/R4/R5/R6/R7 random";
      for (int p = 0; p < 80; p++) begin
         int len;
         len = 20 + int'($urandom_range(180));
         strobe(len, int'($urandom_range(31)));
         for (int c = 1; c < len; c++) begin
            supply_low = ($urandom_range(99) < 2);
            flyback    = (c > len - 4);
            drive_en   = ($urandom_range(99) < 98);
            xray_in    = ($urandom_range(999) < 3);
            xray_clr   = ($urandom_range(99) < 5);
            @(negedge clk);
         end
         supply_low = 1'b0; drive_en = 1'b1; xray_in = 1'b0;
      end
      xray_clr = 1'b0;
      @(negedge clk);
      report();
   end

endmodule